// File: doc/BRIEF.md
# Debug Event Range Detector

This block watches the instruction stream of one processor core and raises debug events. In every cycle it looks at three things. The first is a branch outcome with its target address. The second is an instruction-fetch address. The third is a store, given as a start address and a byte length. Each of the three event kinds has its own enable bit in a select word. All three are compared against one shared address window, set by a start address and an end address.

The whole detector is gated by a single monitor-enable bit taken from the current program status. When that bit is low, nothing is reported. Events found in the same cycle are reported together, one cycle later, as a 3-bit code with one address. Delivery of an interrupt from these events is handled elsewhere.

The window is inclusive at both ends. When the start address is above the end address, the window wraps past the top of the address space. A store counts as an event when any byte it writes falls inside the window.

Top module: `dbg_event_detect`

## Requirements
- R1: While reset (`rstN` low) is applied, and on the first cycle after it, `eventCode` and `eventAddr` are both zero.
- R2: When `monitorEnable` is low in a cycle, `eventCode` is zero in the following cycle, whatever the other inputs are.
- R3: `eventCode` bit 0 (branch) is set one cycle after a cycle in which all of these hold: `branchTaken` is high, `eventSelect` bit 0 is set, `monitorEnable` is high, and `branchTarget` lies in the window. A branch that is not taken never sets bit 0.
- R4: `eventCode` bit 1 (fetch) is set one cycle after a cycle in which all of these hold: `fetchValid` is high, `eventSelect` bit 1 is set, `monitorEnable` is high, and `fetchAddr` lies in the window.
- R5: `eventCode` bit 2 (store) is set one cycle after a cycle in which all of these hold: `storeValid` is high, `eventSelect` bit 2 is set, and `monitorEnable` is high. In addition, at least one of the written bytes must lie in the window. The bytes run from `storeAddr` to `storeAddr + storeLen`, where `storeLen` holds the byte count minus one. The byte span wraps modulo 2^AW.
- R6: The window contains an address p under one of two conditions. If `rangeStart <= rangeEnd`, it contains p when `rangeStart <= p <= rangeEnd`. Otherwise it contains p when `p >= rangeStart` or `p <= rangeEnd`.
- R7: All events found in one cycle are reported together in `eventCode`. `eventAddr` gives the address of the highest-priority reported event, in the order branch target, then fetch address, then store start address. `eventAddr` is zero when `eventCode` is zero.
- R8: Each report depends only on the inputs of the cycle before it. An event does not persist into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| monitorEnable | input | 1 | Master enable from the current program status |
| eventSelect | input | 3 | Per-event enables: bit 0 branch, bit 1 fetch, bit 2 store |
| rangeStart | input | AW | Window start address (inclusive) |
| rangeEnd | input | AW | Window end address (inclusive) |
| branchTaken | input | 1 | A branch completed as taken this cycle |
| branchTarget | input | AW | Target address of the taken branch |
| fetchValid | input | 1 | An instruction fetch occurs this cycle |
| fetchAddr | input | AW | Instruction fetch address |
| storeValid | input | 1 | A store occurs this cycle |
| storeAddr | input | AW | Address of the first stored byte |
| storeLen | input | LW | Stored byte count minus one |
| eventCode | output | 3 | Events found in the previous cycle: bit 0 branch, bit 1 fetch, bit 2 store |
| eventAddr | output | AW | Address of the highest-priority reported event, or zero |

## Verification
Every report is registered once and is never held. A wrong gate, a wrong comparator or a wrong priority therefore shows up on `eventCode` or `eventAddr` in the very next cycle after the stimulus that triggers it.

A comparison that confuses the order of start and end, or that drops the wrap, only shows up when the window or the store span crosses the top of the address space. For that reason the stimulus places addresses right next to both window edges and next to the point where the address space wraps. Stores whose span only reaches the window through their tail bytes expose a check that looks at the first byte alone.

// File: rtl/dbg_event_pkg.sv
package dbg_event_pkg;
  localparam int NUM_EV   = 3;
  localparam int EV_BRANCH = 0;
  localparam int EV_FETCH  = 1;
  localparam int EV_STORE  = 2;

  typedef struct packed {
    logic armStore;
    logic armFetch;
    logic armBranch;
  } armStrobe_t;
endpackage

// File: rtl/dbg_event_ctrl.sv
module dbg_event_ctrl
  import dbg_event_pkg::*;
(
  input  logic              monitorEnable,
  input  logic [NUM_EV-1:0] eventSelect,
  input  logic              branchTaken,
  input  logic              fetchValid,
  input  logic              storeValid,
  output armStrobe_t        arm
);
  // An event kind is armed only when the master enable, its own select bit
  // and its per-cycle qualifier are all present.
  always_comb begin
    arm.armBranch = monitorEnable && eventSelect[EV_BRANCH] && branchTaken;
    arm.armFetch  = monitorEnable && eventSelect[EV_FETCH]  && fetchValid;
    arm.armStore  = monitorEnable && eventSelect[EV_STORE]  && storeValid;
  end
endmodule

// File: rtl/dbg_event_dp.sv
module dbg_event_dp
  import dbg_event_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  armStrobe_t        arm,
  input  logic [AW-1:0]     rangeStart,
  input  logic [AW-1:0]     rangeEnd,
  input  logic [AW-1:0]     branchTarget,
  input  logic [AW-1:0]     fetchAddr,
  input  logic [AW-1:0]     storeAddr,
  input  logic [LW-1:0]     storeLen,
  output logic [NUM_EV-1:0] eventCode,
  output logic [AW-1:0]     eventAddr
);
  // Circular containment: lo..hi inclusive, wrapping when lo > hi.
  function automatic logic inArc(input logic [AW-1:0] p,
                                 input logic [AW-1:0] lo,
                                 input logic [AW-1:0] hi);
    if (lo <= hi) return (p >= lo) && (p <= hi);
    else          return (p >= lo) || (p <= hi);
  endfunction

  logic [AW-1:0]     spanLo [NUM_EV];
  logic [AW-1:0]     spanHi [NUM_EV];
  logic [NUM_EV-1:0] armVec;
  logic [NUM_EV-1:0] hitNext;
  logic [AW-1:0]     addrNext;

  assign armVec = {arm.armStore, arm.armFetch, arm.armBranch};

  always_comb begin
    spanLo[EV_BRANCH] = branchTarget;
    spanHi[EV_BRANCH] = branchTarget;
    spanLo[EV_FETCH]  = fetchAddr;
    spanHi[EV_FETCH]  = fetchAddr;
    spanLo[EV_STORE]  = storeAddr;
    spanHi[EV_STORE]  = storeAddr + AW'(storeLen);
  end

  // One window comparator per event kind; two arcs meet when either one
  // holds the starting point of the other.
  for (genvar i = 0; i < NUM_EV; i++) begin : g_cmp
    assign hitNext[i] = armVec[i] &&
                        (inArc(spanLo[i], rangeStart, rangeEnd) ||
                         inArc(rangeStart, spanLo[i], spanHi[i]));
  end

  always_comb begin
    if (hitNext[EV_BRANCH])     addrNext = branchTarget;
    else if (hitNext[EV_FETCH]) addrNext = fetchAddr;
    else if (hitNext[EV_STORE]) addrNext = storeAddr;
    else                        addrNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventCode <= '0;
      eventAddr <= '0;
    end else begin
      eventCode <= hitNext;
      eventAddr <= addrNext;
    end
  end

  // R7
  addr_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventCode == '0) |-> (eventAddr == '0));

  // R3
  branch_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventCode[EV_BRANCH] |-> (eventAddr == $past(branchTarget)));
endmodule

// File: rtl/dbg_event_detect.sv
module dbg_event_detect
  import dbg_event_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          monitorEnable,
  input  logic [2:0]    eventSelect,
  input  logic [AW-1:0] rangeStart,
  input  logic [AW-1:0] rangeEnd,
  input  logic          branchTaken,
  input  logic [AW-1:0] branchTarget,
  input  logic          fetchValid,
  input  logic [AW-1:0] fetchAddr,
  input  logic          storeValid,
  input  logic [AW-1:0] storeAddr,
  input  logic [LW-1:0] storeLen,
  output logic [2:0]    eventCode,
  output logic [AW-1:0] eventAddr
);
  armStrobe_t arm;

  dbg_event_ctrl u_ctrl (
    .monitorEnable(monitorEnable),
    .eventSelect  (eventSelect),
    .branchTaken  (branchTaken),
    .fetchValid   (fetchValid),
    .storeValid   (storeValid),
    .arm          (arm)
  );

  dbg_event_dp #(.AW(AW), .LW(LW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .arm         (arm),
    .rangeStart  (rangeStart),
    .rangeEnd    (rangeEnd),
    .branchTarget(branchTarget),
    .fetchAddr   (fetchAddr),
    .storeAddr   (storeAddr),
    .storeLen    (storeLen),
    .eventCode   (eventCode),
    .eventAddr   (eventAddr)
  );

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(monitorEnable) |-> (eventCode == '0));

  // R3
  branch_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventCode[0] |-> $past(branchTaken && eventSelect[0]));

  // R4
  fetch_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventCode[1] |-> $past(fetchValid && eventSelect[1]));

  // R5
  store_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventCode[2] |-> $past(storeValid && eventSelect[2]));
endmodule

// File: tb/test_dbg_event_detect.sv
module test_dbg_event_detect;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          monitorEnable = 1'b0;
  logic [2:0]    eventSelect = '0;
  logic [AW-1:0] rangeStart = '0, rangeEnd = '0;
  logic          branchTaken = 1'b0, fetchValid = 1'b0, storeValid = 1'b0;
  logic [AW-1:0] branchTarget = '0, fetchAddr = '0, storeAddr = '0;
  logic [LW-1:0] storeLen = '0;
  logic [2:0]    eventCode;
  logic [AW-1:0] eventAddr;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_event_detect #(.AW(AW), .LW(LW)) i_dbg_event_detect (
    .clk(clk), .rstN(rstN), .monitorEnable(monitorEnable),
    .eventSelect(eventSelect), .rangeStart(rangeStart), .rangeEnd(rangeEnd),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .storeValid(storeValid), .storeAddr(storeAddr), .storeLen(storeLen),
    .eventCode(eventCode), .eventAddr(eventAddr)
  );

  function automatic logic inWin(input logic [AW-1:0] p);
    if (rangeStart <= rangeEnd) return p >= rangeStart && p <= rangeEnd;
    return p >= rangeStart || p <= rangeEnd;
  endfunction

  function automatic logic storeHits();
    for (int k = 0; k <= int'(storeLen); k++)
      if (inWin(storeAddr + AW'(k))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [2:0] modelCode();
    logic [2:0] c;
    c[0] = monitorEnable && eventSelect[0] && branchTaken && inWin(branchTarget);
    c[1] = monitorEnable && eventSelect[1] && fetchValid && inWin(fetchAddr);
    c[2] = monitorEnable && eventSelect[2] && storeValid && storeHits();
    return c;
  endfunction

  function automatic logic [AW-1:0] modelAddr(input logic [2:0] c);
    if (c[0]) return branchTarget;
    if (c[1]) return fetchAddr;
    if (c[2]) return storeAddr;
    return '0;
  endfunction

  task automatic compare(input string tag, input logic [2:0] expC,
                         input logic [AW-1:0] expA);
    checks++;
    if (eventCode !== expC || eventAddr !== expA) begin
      fails++;
      $display("FAIL %s: actual code=%b addr=%h expected code=%b addr=%h",
               tag, eventCode, eventAddr, expC, expA);
    end
  endtask

  // Inputs are set at a negedge; outputs are checked one negedge later.
  task automatic step(input string tag);
    logic [2:0] c;
    logic [AW-1:0] a;
    c = modelCode();
    a = modelAddr(c);
    @(posedge clk);
    @(negedge clk);
    compare(tag, c, a);
  endtask

  task automatic quiet();
    branchTaken = 0; fetchValid = 0; storeValid = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    monitorEnable = 1; eventSelect = 3'b111;
    branchTaken = 1; fetchValid = 1; storeValid = 1;
    rangeStart = 16'h0000; rangeEnd = 16'hFFFF;
    repeat (3) @(negedge clk);
    compare("R1 reset held", 3'b000, '0);
    rstN = 1'b1;
    quiet();
    @(negedge clk);
    compare("R1 after reset", 3'b000, '0);

    rangeStart = 16'h1000; rangeEnd = 16'h2000;
    branchTaken = 1; branchTarget = 16'h1800;
    step("R3 branch in window");
    compare("R3 branch direct", 3'b001, 16'h1800);
    branchTaken = 0;
    step("R3 branch not taken");
    compare("R8 no persistence", 3'b000, '0);

    fetchValid = 1; fetchAddr = 16'h1000; step("R4 R6 fetch at start");
    fetchAddr = 16'h2000; step("R4 R6 fetch at end");
    compare("R6 inclusive end", 3'b010, 16'h2000);
    fetchAddr = 16'h2001; step("R6 fetch past end");
    fetchAddr = 16'h0FFF; step("R6 fetch before start");
    quiet();

    rangeStart = 16'hF000; rangeEnd = 16'h0100;
    fetchValid = 1;
    fetchAddr = 16'hFFFF; step("R6 wrap high");
    compare("R6 wrap high direct", 3'b010, 16'hFFFF);
    fetchAddr = 16'h0000; step("R6 wrap zero");
    fetchAddr = 16'h0200; step("R6 wrap gap");
    compare("R6 wrap gap direct", 3'b000, '0);
    quiet();

    rangeStart = 16'h1000; rangeEnd = 16'h2000;
    storeValid = 1; storeAddr = 16'h0FF0; storeLen = 8'h10;
    step("R5 store tail reaches start");
    compare("R5 tail direct", 3'b100, 16'h0FF0);
    storeLen = 8'h0F; step("R5 store ends before start");
    rangeStart = 16'h0000; rangeEnd = 16'h000A;
    storeAddr = 16'hFFF8; storeLen = 8'h0A; step("R5 store wraps top");
    compare("R5 wrap direct", 3'b100, 16'hFFF8);
    quiet();

    rangeStart = 16'h1000; rangeEnd = 16'h2000;
    branchTaken = 1; branchTarget = 16'h1100;
    fetchValid = 1; fetchAddr = 16'h1200;
    storeValid = 1; storeAddr = 16'h1300; storeLen = 8'h03;
    step("R7 all three");
    compare("R7 all direct", 3'b111, 16'h1100);
    eventSelect = 3'b110; step("R7 R3 branch deselected");
    compare("R7 fetch priority", 3'b110, 16'h1200);
    monitorEnable = 0; step("R2 masked");
    compare("R2 masked direct", 3'b000, '0);
    monitorEnable = 1; eventSelect = 3'b111;
    quiet();
    step("R8 idle");

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] base;
      monitorEnable = ($urandom % 8) != 0;
      eventSelect = 3'($urandom);
      if (n % 50 == 0) begin
        rangeStart = AW'($urandom); rangeEnd = AW'($urandom);
      end
      base = ($urandom % 2) ? rangeStart : rangeEnd;
      branchTaken = 1'($urandom);
      branchTarget = base + AW'($urandom % 16) - AW'(8);
      fetchValid = 1'($urandom);
      fetchAddr = ($urandom % 4 == 0) ? AW'($urandom) : base + AW'($urandom % 16) - AW'(8);
      storeValid = 1'($urandom);
      storeAddr = base - AW'($urandom % 64);
      storeLen = LW'($urandom % 64);
      step("R2-random R3 R4 R5 R6 R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule